// File: doc/BRIEF.md
# Windowed Register File with Overlapping Window Mapping

This block is the integer register file of a processor that uses overlapping register windows. An instruction names registers with 5-bit numbers. Numbers 0 to 7 always reach a small bank of globals. Numbers 8 to 31 are moved into a 64-entry windowed space by adding an offset of 16 entries for each step of the current window. That space is split into two 32-entry banks. Because each window advances by 16 entries while it sees 24 of them, the top eight registers of one window are the same storage as registers 8 to 15 of the next window. Arguments are therefore passed between windows with no copying.

There is one write port and two read ports, and the read ports are asynchronous. The write target is either the destination field of the instruction word or the fixed register 15. The first read port takes either the first source field or the fixed register 14. The second read port always takes the second source field. Write data is chosen from the ALU result, memory read data or the program counter.

The window input is 2 bits wide. In the last window the upper eight registers would fall past the 64-entry space. Any active access that lands there raises an error flag. Such a write is dropped, and such a read returns zero with its valid flag low.

Top module: `winrf_top`

## Requirements
- R1: Register numbers 0 to 7 address the global bank. A value written to one of them in any window is read back in every window.
- R2: Register number n from 8 to 31 in window w maps to physical index (n-8)+16*w. Index bit 5 selects one of the two window banks and bits 4:0 select the entry. Distinct indices hold distinct values.
- R3: A value written to register 24+k in window w reads back as register 8+k in window w+1, for k from 0 to 7.
- R4: With dst_sel=0 the write target is instruction bits 29:25. With dst_sel=1 it is register 15, and bits 29:25 are ignored.
- R5: With src1_sel=0 read port A uses instruction bits 18:14. With src1_sel=1 it uses register 14.
- R6: Read port B uses instruction bits 4:0 and the same window mapping as the other ports.
- R7: When wr_n is 1, no register changes. When wr_n is 0, exactly one register is written, unless the access is out of range.
- R8: When rd_oe_n is 1, both read data outputs are zero and both valid flags are low.
- R9: wsrc selects the write data: 00 selects alu_res, 01 selects mem_rdata, 10 selects pc_val, and 11 selects zero.
- R10: An index of 64 or more (window 3, registers 24 to 31) raises map_err when that access is active. An out-of-range write changes nothing. An out-of-range read gives zero with its valid flag low.
- R11: A synchronous reset clears every register to zero.
- R12: A write lands at the next rising clock edge. A read of the same register in the write cycle returns the old value, and a read in the following cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| window | input | 2 | Current window number |
| instr | input | 32 | Instruction word carrying destination and source fields |
| dst_sel | input | 1 | 0: destination field, 1: fixed register 15 |
| src1_sel | input | 1 | 0: first source field, 1: fixed register 14 |
| wr_n | input | 1 | Write strobe, active low |
| wsrc | input | 2 | Write data source select |
| alu_res | input | 32 | ALU result |
| mem_rdata | input | 32 | Memory read data |
| pc_val | input | 32 | Program counter value |
| rd_oe_n | input | 1 | Read output enable, active low |
| rdata_a | output | 32 | Read port A data |
| valid_a | output | 1 | Read port A data is valid |
| rdata_b | output | 32 | Read port B data |
| valid_b | output | 1 | Read port B data is valid |
| map_err | output | 1 | An active access maps beyond the window space |

## Verification
A wrong translation, such as a missing window offset or a bank bit taken from the wrong position, aliases two registers. The stale or overwritten value then appears on a read port on the first later read of either register. A wide sweep that writes a unique value to every register in every window, then reads all of them back on both ports, exposes any aliasing, including the intended overlap between adjacent windows. A misdecoded strobe, enable or source select shows up one edge after the faulty write, or in the same cycle for the read-side gating.

// File: rtl/winrf_pkg.sv
`timescale 1ns/1ps
package winrf_pkg;

    localparam int ARCH_W     = 5;
    localparam int WIN_W      = 2;
    localparam int GLOBAL_CNT = 8;
    localparam int WIN_STRIDE = 16;
    localparam int BANK_AW    = 5;
    localparam int WBANK_CNT  = 2;

    localparam int GLB_AW    = $clog2(GLOBAL_CNT);
    localparam int BSEL_W    = (WBANK_CNT > 1) ? $clog2(WBANK_CNT) : 1;
    localparam int PHYS_W    = BANK_AW + BSEL_W;
    localparam int SUM_W     = PHYS_W + WIN_W + 1;
    localparam int PHYS_SPAN = WBANK_CNT << BANK_AW;

    // instruction field positions
    localparam int DST_LSB  = 25;
    localparam int SRC1_LSB = 14;
    localparam int SRC2_LSB = 0;

    localparam logic [ARCH_W-1:0] DST_FIXED  = ARCH_W'(15);
    localparam logic [ARCH_W-1:0] SRC1_FIXED = ARCH_W'(14);

    typedef enum logic [1:0] {
        WSRC_ALU  = 2'b00,
        WSRC_MEM  = 2'b01,
        WSRC_PC   = 2'b10,
        WSRC_NONE = 2'b11
    } wsrc_e;

    typedef struct packed {
        logic              glob;
        logic              oob;
        logic [PHYS_W-1:0] phys;
    } rloc_t;

    function automatic rloc_t map_reg(input logic [ARCH_W-1:0] n,
                                      input logic [WIN_W-1:0]  w);
        rloc_t            r;
        logic [SUM_W-1:0] sum;
        sum    = SUM_W'(n) - SUM_W'(GLOBAL_CNT) + SUM_W'(w) * SUM_W'(WIN_STRIDE);
        r.glob = SUM_W'(n) < SUM_W'(GLOBAL_CNT);
        r.oob  = !r.glob && (sum >= SUM_W'(PHYS_SPAN));
        r.phys = r.glob ? PHYS_W'(n) : sum[PHYS_W-1:0];
        return r;
    endfunction

    function automatic logic [BSEL_W-1:0] bank_of(input rloc_t l);
        return l.phys[PHYS_W-1 -: BSEL_W];
    endfunction

endpackage

// File: rtl/winrf_xlate.sv
`timescale 1ns/1ps
module winrf_xlate
    import winrf_pkg::*;
#(
    parameter int PORTS = 3
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [ARCH_W-1:0] arch [PORTS],
    output rloc_t             loc  [PORTS]
);
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign loc[p] = map_reg(arch[p], win);
    end
endmodule

// File: rtl/winrf_bank.sv
`timescale 1ns/1ps
module winrf_bank #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R12: a strobed write is held in the addressed entry after the edge
    a_r12_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

    // R11: entries read zero in the cycle after reset
    a_r11_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (rdata_a == '0 && rdata_b == '0));
endmodule

// File: rtl/winrf_rdmux.sv
`timescale 1ns/1ps
module winrf_rdmux
    import winrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                          oe_n,
    input  rloc_t                         loc,
    input  logic [DW-1:0]                 gdata,
    input  logic [WBANK_CNT-1:0][DW-1:0]  wdata,
    output logic [DW-1:0]                 data,
    output logic                          valid
);
    always_comb begin
        data  = '0;
        valid = 1'b0;
        if (!oe_n && !loc.oob) begin
            valid = 1'b1;
            data  = loc.glob ? gdata : wdata[bank_of(loc)];
        end
    end

    // R8 / R10: data is zero whenever it is flagged invalid
    always_comb begin
        if (!valid) a_r8_invalid_zero: assert (data == '0);
    end
endmodule

// File: rtl/winrf_top.sv
`timescale 1ns/1ps
module winrf_top
    import winrf_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] window,
    input  logic [IW-1:0]    instr,
    input  logic             dst_sel,
    input  logic             src1_sel,
    input  logic             wr_n,
    input  logic [1:0]       wsrc,
    input  logic [DW-1:0]    alu_res,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [DW-1:0]    pc_val,
    input  logic             rd_oe_n,
    output logic [DW-1:0]    rdata_a,
    output logic             valid_a,
    output logic [DW-1:0]    rdata_b,
    output logic             valid_b,
    output logic             map_err
);
    localparam int NPORT = 3;
    localparam int P_WR  = 0;
    localparam int P_A   = 1;
    localparam int P_B   = 2;

    logic [ARCH_W-1:0] arch [NPORT];
    rloc_t             loc  [NPORT];

    assign arch[P_WR] = dst_sel  ? DST_FIXED  : instr[DST_LSB  +: ARCH_W];
    assign arch[P_A]  = src1_sel ? SRC1_FIXED : instr[SRC1_LSB +: ARCH_W];
    assign arch[P_B]  = instr[SRC2_LSB +: ARCH_W];

    winrf_xlate #(.PORTS(NPORT)) u_xlate (
        .win  (window),
        .arch (arch),
        .loc  (loc)
    );

    // write data source
    logic [DW-1:0] wdata;
    always_comb begin
        unique case (wsrc_e'(wsrc))
            WSRC_ALU: wdata = alu_res;
            WSRC_MEM: wdata = mem_rdata;
            WSRC_PC:  wdata = pc_val;
            default:  wdata = '0;
        endcase
    end

    // write enables, one per bank
    logic                 wr_act;
    logic                 g_we;
    logic [WBANK_CNT-1:0] w_we;

    assign wr_act = !wr_n && !loc[P_WR].oob;
    assign g_we   = wr_act && loc[P_WR].glob;

    logic [DW-1:0]                g_ra, g_rb;
    logic [WBANK_CNT-1:0][DW-1:0] w_ra, w_rb;

    winrf_bank #(.DW(DW), .AW(GLB_AW)) u_gbank (
        .clk     (clk),
        .rst     (rst),
        .we      (g_we),
        .waddr   (loc[P_WR].phys[GLB_AW-1:0]),
        .wdata   (wdata),
        .raddr_a (loc[P_A].phys[GLB_AW-1:0]),
        .raddr_b (loc[P_B].phys[GLB_AW-1:0]),
        .rdata_a (g_ra),
        .rdata_b (g_rb)
    );

    for (genvar b = 0; b < WBANK_CNT; b++) begin : g_wbank
        assign w_we[b] = wr_act && !loc[P_WR].glob
                         && (bank_of(loc[P_WR]) == BSEL_W'(b));

        winrf_bank #(.DW(DW), .AW(BANK_AW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (w_we[b]),
            .waddr   (loc[P_WR].phys[BANK_AW-1:0]),
            .wdata   (wdata),
            .raddr_a (loc[P_A].phys[BANK_AW-1:0]),
            .raddr_b (loc[P_B].phys[BANK_AW-1:0]),
            .rdata_a (w_ra[b]),
            .rdata_b (w_rb[b])
        );
    end

    winrf_rdmux #(.DW(DW)) u_rd_a (
        .oe_n  (rd_oe_n),
        .loc   (loc[P_A]),
        .gdata (g_ra),
        .wdata (w_ra),
        .data  (rdata_a),
        .valid (valid_a)
    );

    winrf_rdmux #(.DW(DW)) u_rd_b (
        .oe_n  (rd_oe_n),
        .loc   (loc[P_B]),
        .gdata (g_rb),
        .wdata (w_rb),
        .data  (rdata_b),
        .valid (valid_b)
    );

    assign map_err = (!wr_n && loc[P_WR].oob)
                  || (!rd_oe_n && (loc[P_A].oob || loc[P_B].oob));

    // R7: at most one bank is written per cycle
    a_r7_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0({g_we, w_we}));

    // R7: a high strobe writes nothing
    a_r7_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        wr_n |-> !(g_we || (|w_we)));

    // R8: disabled read ports are blank
    a_r8_oe_blank: assert property (@(posedge clk) disable iff (rst)
        rd_oe_n |-> (!valid_a && !valid_b && rdata_a == '0 && rdata_b == '0));

    // R10: an out-of-range write raises the flag and reaches no bank
    a_r10_oob_write: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && loc[P_WR].oob) |-> (map_err && !g_we && w_we == '0));

    // R12: data written to the location port A keeps reading appears one cycle later
    a_r12_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_act && !rd_oe_n && loc[P_WR] == loc[P_A])
        |=> (!$stable(loc[P_A]) || rd_oe_n || rdata_a == $past(wdata)));
endmodule

// File: tb/test_winrf_top.sv
`timescale 1ns/1ps
module test_winrf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  window;
    logic [31:0] instr;
    logic        dst_sel, src1_sel, wr_n, rd_oe_n;
    logic [1:0]  wsrc;
    logic [31:0] alu_res, mem_rdata, pc_val;
    logic [31:0] rdata_a, rdata_b;
    logic        valid_a, valid_b, map_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] gm [8];
    logic [31:0] wm [64];

    always #2.5 clk = ~clk;

    winrf_top i_winrf_top (
        .clk(clk), .rst(rst), .window(window), .instr(instr),
        .dst_sel(dst_sel), .src1_sel(src1_sel), .wr_n(wr_n), .wsrc(wsrc),
        .alu_res(alu_res), .mem_rdata(mem_rdata), .pc_val(pc_val),
        .rd_oe_n(rd_oe_n), .rdata_a(rdata_a), .valid_a(valid_a),
        .rdata_b(rdata_b), .valid_b(valid_b), .map_err(map_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mexp(input int w, input int n, output bit v);
        int idx;
        v = 1'b1;
        if (n < 8) return gm[n];
        idx = n - 8 + w * 16;
        if (idx > 63) begin
            v = 1'b0;
            return 32'h0;
        end
        return wm[idx];
    endfunction

    task automatic set_instr(input int rd, input int rs1, input int rs2);
        instr        = 32'h0;
        instr[29:25] = 5'(rd);
        instr[18:14] = 5'(rs1);
        instr[4:0]   = 5'(rs2);
    endtask

    // one write cycle; map_err is sampled mid-cycle
    task automatic do_write(input int w, input int rd, input bit dsel,
                            input logic [1:0] src, input logic [31:0] val);
        int tgt, idx;
        logic [31:0] d;
        @(posedge clk); #1;
        window = 2'(w); set_instr(rd, 0, 0);
        dst_sel = dsel; src1_sel = 1'b0; rd_oe_n = 1'b1;
        wsrc = src; alu_res = val; mem_rdata = ~val; pc_val = val ^ 32'h5A5A_0000;
        wr_n = 1'b0;
        tgt = dsel ? 15 : rd;
        idx = tgt - 8 + w * 16;
        @(negedge clk);
        chk($sformatf("R10 err w%0d r%0d", w, tgt), {31'b0, map_err},
            {31'b0, (tgt >= 8 && idx > 63)});
        @(posedge clk); #1;
        wr_n = 1'b1;
        case (src)
            2'b00: d = val;
            2'b01: d = ~val;
            2'b10: d = val ^ 32'h5A5A_0000;
            default: d = 32'h0;
        endcase
        if (tgt < 8) gm[tgt] = d;
        else if (idx <= 63) wm[idx] = d;
    endtask

    task automatic rd_chk(input string tag, input int w, input int na, input int nb);
        logic [31:0] ea, eb;
        bit va, vb;
        @(posedge clk); #1;
        window = 2'(w); set_instr(0, na, nb);
        src1_sel = 1'b0; rd_oe_n = 1'b0; wr_n = 1'b1;
        @(negedge clk);
        ea = mexp(w, na, va);
        eb = mexp(w, nb, vb);
        chk($sformatf("%s A w%0d r%0d", tag, w, na), rdata_a, ea);
        chk($sformatf("%s A valid w%0d r%0d", tag, w, na), {31'b0, valid_a}, {31'b0, va});
        chk($sformatf("R6 %s B w%0d r%0d", tag, w, nb), rdata_b, eb);
        chk($sformatf("R6 %s B valid w%0d r%0d", tag, w, nb), {31'b0, valid_b}, {31'b0, vb});
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) gm[i] = 32'h0;
        for (int i = 0; i < 64; i++) wm[i] = 32'h0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] old, nv;
        bit v;
        rst = 1'b1; window = 2'd0; instr = 32'h0; dst_sel = 1'b0; src1_sel = 1'b0;
        wr_n = 1'b1; rd_oe_n = 1'b1; wsrc = 2'b00;
        alu_res = 32'h0; mem_rdata = 32'h0; pc_val = 32'h0;
        do_reset();

        // R11: everything reads zero after reset
        rd_chk("R11", 0, 3, 20);
        rd_chk("R11", 2, 31, 9);

        // R1 R2 R10: unique value into every register of every window
        for (int w = 0; w < 4; w++)
            for (int n = 0; n < 32; n++)
                do_write(w, n, 1'b0, 2'b00, {8'hA5, 8'(w), 8'(n), 8'h3C});
        for (int w = 0; w < 4; w++)
            for (int n = 0; n < 32; n++)
                rd_chk(n < 8 ? "R1" : (n - 8 + w * 16 > 63 ? "R10" : "R2"), w, n, 31 - n);

        // R3: out register of window k is the in register of window k+1
        for (int k = 0; k < 3; k++) begin
            do_write(k, 24 + k * 2, 1'b0, 2'b00, 32'hC0DE_0000 + 32'(k));
            @(posedge clk); #1;
            window = 2'(k + 1); set_instr(0, 8 + k * 2, 0); rd_oe_n = 1'b0;
            @(negedge clk);
            chk($sformatf("R3 overlap k%0d", k), rdata_a, 32'hC0DE_0000 + 32'(k));
        end

        // R4: fixed destination 15 ignores rd field
        do_write(1, 3, 1'b1, 2'b00, 32'h0F0F_1515);
        rd_chk("R4", 1, 15, 3);
        chk("R4 fixed dst value", mexp(1, 15, v), 32'h0F0F_1515);

        // R5: fixed first source 14
        do_write(2, 14, 1'b0, 2'b00, 32'h1414_2222);
        @(posedge clk); #1;
        window = 2'd2; set_instr(0, 15, 15); src1_sel = 1'b1; rd_oe_n = 1'b0;
        @(negedge clk);
        chk("R5 fixed src1", rdata_a, 32'h1414_2222);
        chk("R5 rs2 unaffected", rdata_b, mexp(2, 15, v));
        @(posedge clk); #1; src1_sel = 1'b0;

        // R7: strobe high writes nothing
        @(posedge clk); #1;
        window = 2'd0; set_instr(20, 0, 0); alu_res = 32'hDEAD_BEEF; wsrc = 2'b00; wr_n = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd_chk("R7", 0, 20, 2);

        // R8: output enable high blanks both ports
        @(posedge clk); #1;
        window = 2'd1; set_instr(0, 12, 2); rd_oe_n = 1'b1;
        @(negedge clk);
        chk("R8 data A", rdata_a, 32'h0);
        chk("R8 data B", rdata_b, 32'h0);
        chk("R8 valid", {30'b0, valid_a, valid_b}, 32'h0);

        // R9: every write source
        do_write(0, 12, 1'b0, 2'b01, 32'h1234_5678);
        rd_chk("R9 mem", 0, 12, 0);
        do_write(0, 12, 1'b0, 2'b10, 32'h1234_5678);
        rd_chk("R9 pc", 0, 12, 0);
        do_write(0, 13, 1'b0, 2'b11, 32'h1234_5678);
        rd_chk("R9 none", 0, 13, 0);

        // R10: out-of-range read raises the flag
        @(posedge clk); #1;
        window = 2'd3; set_instr(0, 28, 5); rd_oe_n = 1'b0;
        @(negedge clk);
        chk("R10 read flag", {31'b0, map_err}, 32'h1);

        // R12: old value in write cycle, new value after the edge
        old = mexp(0, 9, v);
        nv  = 32'h9999_0009;
        @(posedge clk); #1;
        window = 2'd0; set_instr(9, 9, 0); dst_sel = 1'b0; wsrc = 2'b00;
        alu_res = nv; rd_oe_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R12 before edge", rdata_a, old);
        @(posedge clk); #1;
        wr_n = 1'b1;
        wm[1] = nv;
        @(negedge clk);
        chk("R12 after edge", rdata_a, nv);

        // R11: reset mid-run clears everything
        do_reset();
        rd_chk("R11", 1, 4, 30);
        rd_chk("R11", 2, 24, 10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule